// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block watches a bank of general-purpose input pins (184 by default) and turns their activity into a single interrupt request toward the processor. Each pin has its own 32-bit register. In that register software chooses edge or level sensing and the polarity, enables capture, and sets a delivery mask. The register also holds a sticky pending flag, which software clears by writing 1 to it. Writing a register back with the value just read from it therefore acknowledges that pin.

To find the source quickly, the service routine reads two summary words. Each summary bit stands for a group of four neighbouring pins and is set when any pin in the group has a pending flag. Once a pending flag that is not masked appears, the interrupt line rises. It stays high until software writes the end-of-interrupt bit in the master register. After that write the line drops for one cycle and rises again if unmasked work is still pending.

Access is through a plain synchronous register port with byte addresses. Read data appears one cycle after the read strobe.

Top module: `gpio_group_irq_ctrl`

## Requirements
- R1: After reset, every pin register and both summary words read 0, `rdata` is 0 and `irq_out` is low.
- R2: A pin register sits at byte address 4×pin. Its fields are: bit 0 = level mode (1 = level, 0 = edge); bits 2:1 = polarity; bit 3 = capture enable; bit 4 = unmask (1 = delivered); bit 8 = pending; bit 9 = the current level of the pin. A write stores bits 0–4 and ignores bit 9.
- R3: A pin's pending flag is set only by an event seen while that pin's capture enable is 1. Enabling capture later does not capture an earlier event.
- R4: In edge mode the event is found by comparing the pin with its value on the previous clock. Polarity 00 detects falling edges, 01 rising edges, 10 either edge, and 11 never fires. The pending flag is set on the clock edge at which the changed pin is first sampled.
- R5: In level mode, polarity 00 fires while the pin is low and 01 while it is high; 10 and 11 never fire. The flag is set again on every cycle the active level lasts, so clearing it during that time leaves it set.
- R6: Writing 1 to bit 8 clears the pending flag and writing 0 leaves it unchanged. If an event arrives in the same cycle as a clear, the event wins.
- R7: Summary bit g is the OR of the pending flags of pins 4g to 4g+3, regardless of the mask. Groups 0–31 are bits 0–31 of the word at 0x300. Groups 32–45 are bits 0–13 of the word at 0x304, whose other bits read 0.
- R8: `irq_out` rises on the clock after an unmasked pending flag exists. Pending flags that are masked never raise it.
- R9: Once high, `irq_out` stays high until an end-of-interrupt write, even if all pending flags have been cleared.
- R10: Writing 1 to bit 0 at address 0x308 (end of interrupt) drives `irq_out` low for the next cycle. One cycle later the line is high again if any unmasked pending flag remains.
- R11: `rdata` takes the addressed value on the clock edge that samples `rd_en` and holds it otherwise. The master register, unmapped addresses and misaligned addresses read 0. Writes to unmapped or misaligned addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Filtered pin levels |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The pins are driven with single rising and single falling transitions, with held levels and with toggles. Every polarity code is tried in both sensing modes, which separates the rising, falling, both-edge and reserved decodes, and separates level re-arming from one-shot edge capture. Pins in the first group, the last group of word 0, the first group of word 1 and the last group overall are exercised to check how the summary bits are placed. End-of-interrupt writes are made both with work still pending and with nothing pending, which tells the one-cycle re-arm apart from a plain drop. A random phase of pin toggles, configuration writes, clears and reads is then compared cycle by cycle against a behavioural model.

// File: rtl/gpio_gic_pkg.sv
`timescale 1ns/1ps
package gpio_gic_pkg;

  localparam int REG_W = 32;

  // field positions inside a pin register
  localparam int B_LVL = 0;
  localparam int B_POL = 1;
  localparam int B_EN  = 3;
  localparam int B_UNM = 4;
  localparam int B_STS = 8;
  localparam int B_PIN = 9;

  typedef enum logic [1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_e;

  typedef struct packed {
    logic lvl;
    pol_e pol;
    logic en;
    logic unm;
  } pin_cfg_t;

  // event detector shared by every pin cell
  function automatic logic pin_event(input pin_cfg_t c, input logic cur, input logic prev);
    logic hit;
    hit = 1'b0;
    if (c.lvl) begin
      case (c.pol)
        POL_LOW:  hit = ~cur;
        POL_HIGH: hit = cur;
        default:  hit = 1'b0;
      endcase
    end else begin
      case (c.pol)
        POL_LOW:  hit = prev & ~cur;
        POL_HIGH: hit = ~prev & cur;
        POL_BOTH: hit = prev ^ cur;
        default:  hit = 1'b0;
      endcase
    end
    return hit;
  endfunction

  // bits 4:0 of a write word to a configuration record
  function automatic pin_cfg_t cfg_from_bits(input logic [4:0] b);
    pin_cfg_t c;
    c.lvl = b[B_LVL];
    c.pol = pol_e'(b[B_POL +: 2]);
    c.en  = b[B_EN];
    c.unm = b[B_UNM];
    return c;
  endfunction

  // configuration record plus flags back to a readable word
  function automatic logic [REG_W-1:0] pack_word(input pin_cfg_t c, input logic sts, input logic lvl_now);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_LVL]      = c.lvl;
    w[B_POL +: 2] = c.pol;
    w[B_EN]       = c.en;
    w[B_UNM]      = c.unm;
    w[B_STS]      = sts;
    w[B_PIN]      = lvl_now;
    return w;
  endfunction

  // last pin index covered by group g
  function automatic int grp_hi(input int g, input int per, input int npins);
    int hi;
    hi = g * per + per - 1;
    if (hi > npins - 1) hi = npins - 1;
    return hi;
  endfunction

endpackage

// File: rtl/gpio_gic_pin.sv
`timescale 1ns/1ps
module gpio_gic_pin
  import gpio_gic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] word_o,
  output logic             pend_o,
  output logic             unm_o,
  output logic             en_o,
  output logic             clr_o
);

  pin_cfg_t cfg_q;
  logic     sts_q;
  logic     prev_q;
  logic     evt;

  logic wbits_unused;
  assign wbits_unused = ^{wdata_i[REG_W-1:B_PIN], wdata_i[B_STS-1:B_UNM+1]};

  assign evt   = pin_event(cfg_q, pin_i, prev_q);
  assign clr_o = wr_i & wdata_i[B_STS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sts_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      sts_q  <= (sts_q & ~clr_o) | (cfg_q.en & evt);
      if (wr_i) cfg_q <= cfg_from_bits(wdata_i[B_UNM:B_LVL]);
    end
  end

  assign word_o = pack_word(cfg_q, sts_q, pin_i);
  assign pend_o = sts_q;
  assign unm_o  = cfg_q.unm;
  assign en_o   = cfg_q.en;

endmodule

// File: rtl/gpio_gic_summary.sv
`timescale 1ns/1ps
module gpio_gic_summary
  import gpio_gic_pkg::*;
#(
  parameter int NUM_PINS       = 184,
  parameter int PINS_PER_GROUP = 4,
  parameter int SUM_W          = 64
) (
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [SUM_W-1:0]    sum_o
);

  localparam int NUM_GROUPS = (NUM_PINS + PINS_PER_GROUP - 1) / PINS_PER_GROUP;

  for (genvar g = 0; g < SUM_W; g++) begin : g_sum
    if (g < NUM_GROUPS) begin : g_live
      localparam int LO = g * PINS_PER_GROUP;
      localparam int HI = grp_hi(g, PINS_PER_GROUP, NUM_PINS);
      assign sum_o[g] = |pend_i[HI:LO];
    end else begin : g_pad
      assign sum_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_gic_deliver.sv
`timescale 1ns/1ps
module gpio_gic_deliver #(
  parameter int NUM_PINS = 184
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [NUM_PINS-1:0] unm_i,
  input  logic                eoi_i,
  output logic                any_o,
  output logic                irq_o
);

  logic irq_q;

  assign any_o = |(pend_i & unm_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (eoi_i) irq_q <= 1'b0;
    else            irq_q <= irq_q | any_o;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gpio_group_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_group_irq_ctrl
  import gpio_gic_pkg::*;
#(
  parameter int NUM_PINS       = 184,
  parameter int PINS_PER_GROUP = 4,
  parameter int ADDR_W         = 10,
  parameter int SUM_BASE       = 768
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output logic                irq_out
);

  localparam int WIDX_W    = ADDR_W - 2;
  localparam int PIN_IDX_W = $clog2(NUM_PINS);
  localparam int SUM_W     = 64;
  localparam int SUM0_IDX  = SUM_BASE / 4;
  localparam int SUM1_IDX  = SUM0_IDX + 1;
  localparam int MSTR_IDX  = SUM0_IDX + 2;
  localparam int EOI_BIT   = 0;

  logic [WIDX_W-1:0] word_idx;
  logic              aligned;
  logic              pin_hit;
  logic              sum0_hit;
  logic              sum1_hit;
  logic              mstr_hit;
  logic              eoi_hit;
  logic              any_unm;

  logic [REG_W-1:0]    pin_word [NUM_PINS];
  logic [NUM_PINS-1:0] pend_vec;
  logic [NUM_PINS-1:0] unm_vec;
  logic [NUM_PINS-1:0] en_vec;
  logic [NUM_PINS-1:0] clr_vec;
  logic [SUM_W-1:0]    sum_vec;
  logic [REG_W-1:0]    rd_word;
  logic [REG_W-1:0]    rdata_q;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign pin_hit  = aligned && (word_idx < WIDX_W'(NUM_PINS));
  assign sum0_hit = aligned && (word_idx == WIDX_W'(SUM0_IDX));
  assign sum1_hit = aligned && (word_idx == WIDX_W'(SUM1_IDX));
  assign mstr_hit = aligned && (word_idx == WIDX_W'(MSTR_IDX));
  assign eoi_hit  = wr_en && mstr_hit && wdata[EOI_BIT];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic wr_sel;
    assign wr_sel = wr_en && aligned && (word_idx == WIDX_W'(p));
    gpio_gic_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin_in[p]),
      .wr_i    (wr_sel),
      .wdata_i (wdata),
      .word_o  (pin_word[p]),
      .pend_o  (pend_vec[p]),
      .unm_o   (unm_vec[p]),
      .en_o    (en_vec[p]),
      .clr_o   (clr_vec[p])
    );
  end

  gpio_gic_summary #(
    .NUM_PINS       (NUM_PINS),
    .PINS_PER_GROUP (PINS_PER_GROUP),
    .SUM_W          (SUM_W)
  ) u_sum (
    .pend_i (pend_vec),
    .sum_o  (sum_vec)
  );

  gpio_gic_deliver #(
    .NUM_PINS (NUM_PINS)
  ) u_dlv (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_vec),
    .unm_i  (unm_vec),
    .eoi_i  (eoi_hit),
    .any_o  (any_unm),
    .irq_o  (irq_out)
  );

  always_comb begin
    rd_word = '0;
    if (pin_hit)       rd_word = pin_word[word_idx[PIN_IDX_W-1:0]];
    else if (sum0_hit) rd_word = sum_vec[REG_W-1:0];
    else if (sum1_hit) rd_word = sum_vec[SUM_W-1:REG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/gpio_gic_chk.sv
`timescale 1ns/1ps
module gpio_gic_chk #(
  parameter int NUM_PINS = 184,
  parameter int SUM_W    = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_out,
  input logic                eoi_hit,
  input logic                any_unm,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] en_vec,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [SUM_W-1:0]    sum_vec
);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_unm && !eoi_hit) |=> irq_out);

  // R8
  no_spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && !any_unm && !eoi_hit) |=> !irq_out);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !eoi_hit) |=> irq_out);

  // R10
  eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> !irq_out);

  // R7
  summary_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sum_vec) == (|pend_vec));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
    // R3
    pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_vec[i]) |-> $past(en_vec[i]));
    // R6
    pend_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_vec[i]) |-> $past(clr_vec[i]));
  end

endmodule

bind gpio_group_irq_ctrl gpio_gic_chk #(
  .NUM_PINS (NUM_PINS),
  .SUM_W    (SUM_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_out  (irq_out),
  .eoi_hit  (eoi_hit),
  .any_unm  (any_unm),
  .pend_vec (pend_vec),
  .en_vec   (en_vec),
  .clr_vec  (clr_vec),
  .sum_vec  (sum_vec)
);

// File: tb/gpio_group_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_group_irq_ctrl_tb_top;

  localparam int NP    = 184;
  localparam int AW    = 10;
  localparam int A_S0  = 'h300;
  localparam int A_S1  = 'h304;
  localparam int A_MST = 'h308;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq_out;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  cmp_on  = 1'b0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  gpio_group_irq_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .pin_in (pin_in), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata), .irq_out (irq_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit       m_lvl [NP];
  bit [1:0] m_pol [NP];
  bit       m_en  [NP];
  bit       m_unm [NP];
  bit       m_sts [NP];
  bit       m_prv [NP];
  bit       m_irq;
  bit [31:0] m_rdata;

  function automatic bit ref_evt(bit lvl, bit [1:0] pol, bit cur, bit prv);
    if (lvl) return (pol == 2'd1 && cur) || (pol == 2'd0 && !cur);
    return (pol == 2'd1 && cur && !prv) || (pol == 2'd0 && !cur && prv) ||
           (pol == 2'd2 && cur != prv);
  endfunction

  function automatic bit [31:0] ref_read(int a);
    bit [31:0] r;
    bit [63:0] s;
    r = 0;
    s = 0;
    if (a % 4 != 0) return 0;
    if (a / 4 < NP) begin
      r = {22'd0, pin_in[a/4], m_sts[a/4], 3'd0, m_unm[a/4], m_en[a/4], m_pol[a/4], m_lvl[a/4]};
      return r;
    end
    for (int p = 0; p < NP; p++) if (m_sts[p]) s[p/4] = 1'b1;
    if (a == A_S0) return s[31:0];
    if (a == A_S1) return s[63:32];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_lvl[p] = 0; m_pol[p] = 0; m_en[p] = 0; m_unm[p] = 0; m_sts[p] = 0; m_prv[p] = 0;
      end
      m_irq = 0;
      m_rdata = 0;
    end else begin
      bit any, eoi, clr, ev, wsel;
      any = 0;
      for (int p = 0; p < NP; p++) any |= m_sts[p] & m_unm[p];
      if (rd_en) m_rdata = ref_read(int'(addr));
      eoi = wr_en && int'(addr) == A_MST && wdata[0];
      m_irq = eoi ? 1'b0 : (m_irq | any);
      for (int p = 0; p < NP; p++) begin
        wsel = wr_en && int'(addr) == p * 4;
        clr  = wsel && wdata[8];
        ev   = ref_evt(m_lvl[p], m_pol[p], pin_in[p], m_prv[p]);
        m_sts[p] = (m_sts[p] && !clr) || (m_en[p] && ev);
        m_prv[p] = pin_in[p];
        if (wsel) begin
          m_lvl[p] = wdata[0]; m_pol[p] = wdata[2:1]; m_en[p] = wdata[3]; m_unm[p] = wdata[4];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R8 irq_out vs model", {31'd0, irq_out}, {31'd0, m_irq});
      check("R11 rdata vs model", rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_pin(input int p, input bit v);
    @(negedge clk);
    pin_in[p] = v;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // ---------------- directed and random sequences ----------------
  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1 reset state
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    check("R1 rdata after reset", rdata, 32'd0);
    rd_reg(0, d);     check("R1 pin0 reg", d, 32'd0);
    rd_reg(A_S0, d);  check("R1 summary0", d, 32'd0);

    // R2 field layout, R4 rising edge, R7 summary, R8 masked
    wr_reg(20, 32'h0A);
    rd_reg(20, d);    check("R2 pin5 readback", d, 32'h0A);
    set_pin(5, 1);
    rd_reg(20, d);    check("R4 rising pin5", d, 32'h30A);
    rd_reg(A_S0, d);  check("R7 group1 bit", d, 32'h2);
    check("R8 masked no irq", {31'd0, irq_out}, 32'd0);

    // R6 write 0 keeps, R8 unmask raises
    wr_reg(20, 32'h1A);
    tick();
    check("R8 unmasked irq", {31'd0, irq_out}, 32'd1);
    rd_reg(20, d);    check("R6 write0 keeps status", d, 32'h31A);
    wr_reg(20, d);
    rd_reg(20, d);    check("R6 writeback clears", d, 32'h21A);
    check("R9 irq held after clear", {31'd0, irq_out}, 32'd1);
    wr_reg(A_MST, 32'h1);
    check("R10 eoi drops irq", {31'd0, irq_out}, 32'd0);
    tick();
    check("R10 nothing pending stays low", {31'd0, irq_out}, 32'd0);

    // R4 polarity codes
    set_pin(5, 0);
    rd_reg(20, d);    check("R4 falling ignored pol01", d, 32'h01A);
    wr_reg(4, 32'h08);
    set_pin(1, 1);
    set_pin(1, 0);
    rd_reg(4, d);     check("R4 falling pol00 pin1", d, 32'h108);
    wr_reg(0, 32'h0C);
    set_pin(0, 1);
    rd_reg(0, d);     check("R4 both-edge rise pin0", d, 32'h30C);
    wr_reg(0, 32'h10C);
    rd_reg(0, d);     check("R6 w1c pin0", d, 32'h20C);
    set_pin(0, 0);
    rd_reg(0, d);     check("R4 both-edge fall pin0", d, 32'h10C);
    wr_reg(8, 32'h0E);
    set_pin(2, 1);
    rd_reg(8, d);     check("R4 pol11 never fires", d, 32'h20E);

    // R3 capture enable
    wr_reg(12, 32'h02);
    set_pin(3, 1);
    rd_reg(12, d);    check("R3 disabled no capture", d, 32'h202);
    wr_reg(12, 32'h0A);
    rd_reg(12, d);    check("R3 late enable no capture", d, 32'h20A);
    rd_reg(A_S0, d);  check("R7 group0 from pins0-1", d, 32'h1);

    // R5 level mode
    wr_reg('h208, 32'h1B);
    set_pin(130, 1);
    rd_reg('h208, d); check("R5 level high sets", d, 32'h31B);
    wr_reg('h208, 32'h11B);
    rd_reg('h208, d); check("R5 clear while active", d, 32'h31B);
    rd_reg(A_S1, d);  check("R7 group32 in word1 bit0", d, 32'h1);
    set_pin(130, 0);
    wr_reg('h208, 32'h11B);
    rd_reg('h208, d); check("R5 clear after inactive", d, 32'h01B);
    check("R9 irq held", {31'd0, irq_out}, 32'd1);
    wr_reg(A_MST, 32'h1);
    tick();
    check("R10 no pending stays low", {31'd0, irq_out}, 32'd0);
    wr_reg('h20C, 32'h0D);
    set_pin(131, 1);
    rd_reg('h20C, d); check("R5 level pol10 never", d, 32'h20D);

    // R7 group placement edges
    wr_reg('h2DC, 32'h0A);
    set_pin(183, 1);
    rd_reg(A_S1, d);  check("R7 group45 word1 bit13", d, 32'h2000);
    wr_reg('h1FC, 32'h0A);
    set_pin(127, 1);
    rd_reg(A_S0, d);  check("R7 group31 word0 bit31", d, 32'h80000001);

    // R10 eoi with pending work
    wr_reg('h2DC, 32'h1A);
    tick();
    check("R8 irq for pin183", {31'd0, irq_out}, 32'd1);
    wr_reg(A_MST, 32'h1);
    check("R10 low one cycle", {31'd0, irq_out}, 32'd0);
    tick();
    check("R10 reasserts pending", {31'd0, irq_out}, 32'd1);

    // R11 unmapped and misaligned
    rd_reg('h2E0, d); check("R11 unmapped reads 0", d, 32'd0);
    rd_reg(A_MST, d); check("R11 master reads 0", d, 32'd0);
    wr_reg('h2E0, 32'hFFFFFFFF);
    wr_reg('h2DE, 32'h100);
    rd_reg('h2DC, d); check("R11 misaligned write ignored", d, 32'h31A);
    rd_reg(A_S1, d);  check("R11 summary unchanged", d, 32'h2000);

    // random phase on the first two groups, compared against the model
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = int'($urandom % 10);
      if (k < 4)      set_pin(int'($urandom % 8), 1'($urandom));
      else if (k < 6) wr_reg(int'($urandom % 8) * 4, $urandom & 32'h11F);
      else if (k < 7) wr_reg(A_MST, 32'h1);
      else if (k < 9) rd_reg(int'($urandom % 8) * 4, d);
      else            rd_reg((k % 2 == 0) ? A_S0 : A_S1, d);
    end
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule